// File: doc/BRIEF.md
# Scan Chain with Automatic Test Sequencer

This block is a single chain of mux-input scan flip-flops wrapped around a small combinational circuit under test. A built-in sequencer runs a complete scan test with no outside help. It loads a test pattern serially and drops into functional mode for one capture cycle, or for two back-to-back cycles when a launch/capture pair is wanted. It then unloads the captured response and compares every bit as it leaves the chain. A sticky fail flag reports any mismatch, and a one-cycle done pulse marks the end of the test.

The chain can also be driven by hand. With test mode on and the sequencer idle, the dedicated scan-enable and serial scan input shift the chain directly, and the serial scan output shows the last stage. With test mode off the sequencer is held idle and every stage loads its functional value on each clock.

A build parameter selects overlapped operation. In that mode the unload phase shifts the next pattern in while the response is shifted out, so the following test can begin directly with capture.

The circuit under test makes stage i's functional input equal to q[i] XOR q[(i+N-1) mod N], where q is the chain state and N the chain length.

Top module: `scan_test_top`

## Requirements
- R1: Each stage loads its serial input when the effective scan enable is 1 and its functional input when it is 0; the functional input is d[i] = q[i] ^ q[(i+N-1) mod N].
- R2: The stages form one chain: scan_in feeds stage 0, stage i feeds stage i+1, and stage N-1 drives scan_out. With test_mode=1 and the sequencer idle, scan_enable=1 shifts the chain by one place per clock, and scan_enable=0 leaves the chain unchanged.
- R3: After an accepted start, the load phase shifts for exactly N cycles, entering pattern[N-1] first, so that stage i ends up holding pattern[i].
- R4: Capture lasts one functional cycle, or two consecutive functional cycles when at_speed was 1 at the accepted start.
- R5: The unload phase shifts for N cycles and compares the bit on scan_out in unload cycle k (k = 0..N-1) against expected[N-1-k]. done is high for exactly one cycle. It rises L clock edges after the edge that accepts start, where L = N + C + N for a test that includes a load phase, and C is the number of capture cycles.
- R6: fail clears on the edge that accepts start. It sets after the first mismatching bit and stays set, including after done, until the next accepted start.
- R7: A start pulse that arrives while a test is running is ignored: it causes no extra done and does not change the latency.
- R8: While test_mode=0 the sequencer returns to idle and aborts any running test without a done pulse. The effective scan enable is forced to 0, whatever scan_enable is, so the chain loads its functional values on every clock.
- R9: With OVERLAP=1, the unload phase shifts in the pattern present on the cycle capture ends, entering bit N-1 first. After such a test, a start skips the load phase (L = N + C). Reset, test_mode=0, or a manual shift cancels this skip.
- R10: Synchronous active-low reset clears every stage, idles the sequencer, and drives done and fail to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | Dedicated test mode; 0 gives purely functional operation |
| scan_enable | input | 1 | Dedicated manual scan enable, used while the sequencer is idle |
| scan_in | input | 1 | Manual serial scan input |
| scan_out | output | 1 | Serial output of the last stage |
| start | input | 1 | Starts a sequenced test when idle and in test mode |
| at_speed | input | 1 | Selects a two-cycle launch/capture |
| pattern | input | CHAIN_LEN | Stimulus pattern; bit i is destined for stage i |
| expected | input | CHAIN_LEN | Expected response; bit i is compared with stage i's captured value |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |

## Verification
The bench builds the block with CHAIN_LEN=6 and OVERLAP=1. The short chain keeps each test to a handful of cycles, so bit ordering can be checked exhaustively at every position, including mismatches on the first and on the last unloaded bit. Overlap mode puts both latencies within reach of one build: the full-load latency on the first test and after any disturbance, and the skipped-load latency on a preloaded chain. A readback through manual shifting then confirms what the unload phase left behind.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOAD   = 2'd1,
    PH_CAPT   = 2'd2,
    PH_UNLOAD = 2'd3
  } phase_e;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic se,
  input  logic si,
  input  logic d,
  output logic q
);
  logic nxt;

  always_comb begin
    nxt = se ? si : d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (en) begin
      q <= nxt;
    end
  end
endmodule

// File: rtl/scan_cut.sv
module scan_cut #(
  parameter int N = 16
) (
  input  logic [N-1:0] q,
  output logic [N-1:0] d
);
  for (genvar i = 0; i < N; i++) begin : g_xor
    assign d[i] = q[i] ^ q[(i + N - 1) % N];
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         se,
  input  logic         si,
  input  logic [N-1:0] d,
  output logic [N-1:0] q,
  output logic         so
);
  logic [N-1:0] link;

  for (genvar i = 0; i < N; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign link[i] = si;
    end else begin : g_body
      assign link[i] = q[i-1];
    end
    scan_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .se   (se),
      .si   (link[i]),
      .d    (d[i]),
      .q    (q[i])
    );
  end

  assign so = q[N-1];

  // R2: an enabled shift moves every stage one place toward scan_out
  a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    (en && se) |=> (q[N-1:1] == $past(q[N-2:0])));

  // R1: an enabled functional clock loads the circuit-under-test value
  a_r1_func_load: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !se) |=> (q == $past(d)));
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int N       = 16,
  parameter bit OVERLAP = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_mode,
  input  logic         ext_se,
  input  logic         ext_si,
  input  logic         start,
  input  logic         at_speed,
  input  logic [N-1:0] pattern,
  input  logic [N-1:0] expected,
  input  logic         chain_out,
  output logic         se,
  output logic         si,
  output logic         en,
  output logic         done,
  output logic         fail
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  phase_e        state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [N-1:0]  preg, preg_n;
  logic [N-1:0]  ereg, ereg_n;
  logic          at_l, at_n;
  logic          primed, primed_n;
  logic          done_q, done_n;
  logic          fail_q, fail_n;
  logic          start_ok;

  assign start_ok = test_mode && (state == PH_IDLE) && start;

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    preg_n   = preg;
    ereg_n   = ereg;
    at_n     = at_l;
    primed_n = primed;
    done_n   = 1'b0;
    fail_n   = fail_q;
    if (!test_mode) begin
      state_n  = PH_IDLE;
      cnt_n    = '0;
      primed_n = 1'b0;
    end else begin
      unique case (state)
        PH_IDLE: begin
          if (ext_se) primed_n = 1'b0;
          if (start) begin
            preg_n   = pattern;
            ereg_n   = expected;
            at_n     = at_speed;
            fail_n   = 1'b0;
            cnt_n    = '0;
            state_n  = (OVERLAP && primed && !ext_se) ? PH_CAPT : PH_LOAD;
            primed_n = 1'b0;
          end
        end
        PH_LOAD: begin
          preg_n = preg << 1;
          cnt_n  = cnt + CW'(1);
          if (cnt == LAST) begin
            state_n = PH_CAPT;
            cnt_n   = '0;
          end
        end
        PH_CAPT: begin
          if (at_l && (cnt == '0)) begin
            cnt_n = CW'(1);
          end else begin
            state_n = PH_UNLOAD;
            cnt_n   = '0;
            if (OVERLAP) preg_n = pattern;
          end
        end
        PH_UNLOAD: begin
          preg_n = preg << 1;
          ereg_n = ereg << 1;
          if (chain_out != ereg[N-1]) fail_n = 1'b1;
          cnt_n = cnt + CW'(1);
          if (cnt == LAST) begin
            state_n  = PH_IDLE;
            cnt_n    = '0;
            done_n   = 1'b1;
            primed_n = OVERLAP;
          end
        end
        default: state_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      preg   <= '0;
      ereg   <= '0;
      at_l   <= 1'b0;
      primed <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      preg   <= preg_n;
      ereg   <= ereg_n;
      at_l   <= at_n;
      primed <= primed_n;
      done_q <= done_n;
      fail_q <= fail_n;
    end
  end

  always_comb begin
    if (state == PH_IDLE) begin
      se = test_mode && ext_se;
      si = ext_si;
    end else begin
      se = test_mode && ((state == PH_LOAD) || (state == PH_UNLOAD));
      si = ((state == PH_UNLOAD) && !OVERLAP) ? 1'b0 : preg[N-1];
    end
    en = !test_mode || (state != PH_IDLE) || ext_se;
  end

  assign done = done_q;
  assign fail = fail_q;

  // R5: done lasts a single cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: leaving test mode forces the sequencer idle
  a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> (state == PH_IDLE));

  // R6: fail only clears on an accepted start
  a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !start_ok) |=> fail_q);

  // R3: the load phase advances its bit position by one per cycle
  a_r3_load_count: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && (state == PH_LOAD) && (cnt != LAST)) |=>
      ((state == PH_LOAD) && (cnt == $past(cnt) + CW'(1))));

  // R4: single capture goes straight to unload
  a_r4_capture_len: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && (state == PH_CAPT) && !at_l) |=> (state == PH_UNLOAD));

  // R5: the bit position never passes the chain length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(N));
endmodule

// File: rtl/scan_test_top.sv
module scan_test_top #(
  parameter int CHAIN_LEN = 16,
  parameter bit OVERLAP   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 test_mode,
  input  logic                 scan_enable,
  input  logic                 scan_in,
  output logic                 scan_out,
  input  logic                 start,
  input  logic                 at_speed,
  input  logic [CHAIN_LEN-1:0] pattern,
  input  logic [CHAIN_LEN-1:0] expected,
  output logic                 done,
  output logic                 fail
);
  logic [CHAIN_LEN-1:0] q;
  logic [CHAIN_LEN-1:0] d;
  logic                 se;
  logic                 si;
  logic                 en;
  logic                 so;

  scan_cut #(.N(CHAIN_LEN)) u_cut (
    .q(q),
    .d(d)
  );

  scan_chain #(.N(CHAIN_LEN)) u_chain (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .se   (se),
    .si   (si),
    .d    (d),
    .q    (q),
    .so   (so)
  );

  scan_seq #(.N(CHAIN_LEN), .OVERLAP(OVERLAP)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_mode(test_mode),
    .ext_se   (scan_enable),
    .ext_si   (scan_in),
    .start    (start),
    .at_speed (at_speed),
    .pattern  (pattern),
    .expected (expected),
    .chain_out(so),
    .se       (se),
    .si       (si),
    .en       (en),
    .done     (done),
    .fail     (fail)
  );

  assign scan_out = so;

  // R8: with test mode off the chain never shifts
  a_r8_no_shift_off: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> !se);
endmodule

// File: tb/scan_test_top_test.sv
module scan_test_top_test;
  localparam int N = 6;

  typedef struct {
    int   s;
    int   lat;
    logic fl;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         test_mode;
  logic         scan_enable;
  logic         scan_in;
  logic         scan_out;
  logic         start;
  logic         at_speed;
  logic [N-1:0] pattern;
  logic [N-1:0] expected;
  logic         done;
  logic         fail;

  int tests = 0;
  int errors = 0;
  int cyc = 0;
  item_t sb[$];
  logic [N-1:0] chain_m = '0;
  bit primed_m = 1'b0;
  bit prev_done = 1'b0;

  always #2 clk = ~clk;

  scan_test_top #(.CHAIN_LEN(N), .OVERLAP(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .scan_enable(scan_enable),
    .scan_in(scan_in), .scan_out(scan_out), .start(start), .at_speed(at_speed),
    .pattern(pattern), .expected(expected), .done(done), .fail(fail)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] cut(input logic [N-1:0] v);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[i] ^ v[(i + N - 1) % N];
    return r;
  endfunction

  // monitor: pops expected results as done pulses appear
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (done === 1'b1) begin
        if (prev_done) check("R5 done longer than one cycle", 1, 0);
        if (sb.size() == 0) begin
          check("R7/R8 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check("R5 latency", cyc - it.s - 1, it.lat);
          check("R6 fail at done", fail, it.fl);
        end
      end
      prev_done = (done === 1'b1);
    end
  end

  // manual shift: checks current contents bit by bit while loading nv (R2)
  task automatic xchg(input logic [N-1:0] nv, input logic [N-1:0] cur, input string req);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check(req, scan_out, cur[N-1-k]);
      scan_enable = 1'b1;
      scan_in = nv[N-1-k];
    end
    @(negedge clk);
    scan_enable = 1'b0;
    scan_in = 1'b0;
    chain_m = nv;
    primed_m = 1'b0;
  endtask

  // driver: starts a test and pushes the expected outcome
  task automatic run_test(input logic [N-1:0] pat, input logic [N-1:0] nxt,
                          input logic [N-1:0] flip, input logic at, input bit extra);
    logic [N-1:0] used;
    logic [N-1:0] cap;
    item_t it;
    int guard;
    used = primed_m ? chain_m : pat;
    cap = at ? cut(cut(used)) : cut(used);
    @(negedge clk);
    start = 1'b1;
    pattern = pat;
    expected = cap ^ flip;
    at_speed = at;
    it.s = cyc;
    it.lat = (primed_m ? 0 : N) + N + (at ? 2 : 1);
    it.fl = (flip != '0);
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    pattern = nxt;
    check("R6 fail cleared by start", fail, 0);
    if (extra) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (sb.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 200) check("R5 done never seen", 1, 0);
    chain_m = nxt;
    primed_m = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; test_mode = 1'b1; scan_enable = 1'b0; scan_in = 1'b0;
    start = 1'b0; at_speed = 1'b0; pattern = '0; expected = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 done after reset", done, 0);
    check("R10 fail after reset", fail, 0);
    check("R10 scan_out after reset", scan_out, 0);

    // R2: manual load, hold with scan_enable low, readback
    xchg(6'b101101, 6'b000000, "R10 chain cleared");
    repeat (4) @(negedge clk);
    xchg(6'b100110, 6'b101101, "R2 manual shift and hold");

    // R1/R8: one functional clock with scan_enable high but test_mode low
    @(negedge clk);
    test_mode = 1'b0; scan_enable = 1'b1;
    @(negedge clk);
    test_mode = 1'b1; scan_enable = 1'b0;
    xchg(6'b000000, cut(6'b100110), "R1 R8 functional capture");

    // R3/R5: full load, single capture, passing
    run_test(6'b110010, 6'b011011, '0, 1'b0, 1'b0);
    // R4/R9: preloaded chain, at-speed double capture
    run_test(6'b000000, 6'b001110, '0, 1'b1, 1'b0);
    // R6: mismatch on the first unloaded bit, fail must stick
    run_test(6'b000000, 6'b111000, 6'b100000, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R6 fail sticky in idle", fail, 1);
    // R5: mismatch only on the last unloaded bit
    run_test(6'b000000, 6'b010101, 6'b000001, 1'b1, 1'b0);
    // R6: passing test after a failure clears fail
    run_test(6'b000000, 6'b101010, '0, 1'b0, 1'b0);
    // R7: start pulse during a running test is ignored
    run_test(6'b000000, 6'b110011, '0, 1'b0, 1'b1);

    // R9: unload left the next pattern in the chain; manual shift unprimes
    xchg(6'b011110, 6'b110011, "R9 preload contents");
    run_test(6'b011110, 6'b000111, '0, 1'b1, 1'b0);

    // R8: abort a running test with test_mode low, no done expected
    @(negedge clk);
    start = 1'b1; pattern = 6'b111111; at_speed = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    test_mode = 1'b0;
    @(negedge clk);
    test_mode = 1'b1;
    repeat (3 * N) @(negedge clk);
    check("R8 abort leaves done low", done, 0);
    primed_m = 1'b0;
    // R9: after abort the next test runs a full load
    run_test(6'b100001, 6'b001100, '0, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end
endmodule